// File: doc/BRIEF.md
# Double-Banked Piecewise-Linear Transfer Curve Stage

This block applies a per-channel transfer curve to RGB pixels. The curve is either a fixed built-in shape or a piecewise-linear curve held in one of two point banks, bank A or bank B. Each curve point holds a base value and a slope delta for every channel. The input range of a channel is divided into equal regions. Each region has its own segment count (a power of two) and a starting point offset. The output is the base of the selected point plus the delta scaled by the input's position inside its segment.

Software loads the bank that is not in use through one sequential data port whose point index advances by itself. While that happens the other bank keeps serving pixels. Software then requests the new mode, and the change takes effect at the next frame boundary. A status code reports which bank is live.

Top module: `gamma_pwl_lut`

## Requirements
- R1: In reset and right after it, `pix_vld_o` is 0, `pix_o` is 0 and `status_o` is 0. The pending mode and the live mode are both 0 (bypass), the channel mask is 7 and the bank select is 0.
- R2: Pixels take one cycle. `pix_vld_o` follows `pix_vld_i` one cycle later. In live mode 0, and in the unused modes 5 to 7, each channel outputs the input shifted left by OUT_W-IN_W bits. Channel c sits at bits [c*W +: W], with red as c=0, green as c=1 and blue as c=2.
- R3: A write to address 3 (data) stores one word. The words of a point arrive in this order: red base, green base, blue base, red delta, green delta, blue delta. After the sixth word the point index goes up by one, wrapping at NUM_PTS. A write to address 2 sets the index to wdata and restarts at the red base word.
- R4: Address 1 bits [2:0] form a channel mask, with bit 0 for red, bit 1 for green and bit 2 for blue. When a channel's bit is 0, that channel's base and delta words leave the stored value unchanged, but they still advance the word position.
- R5: Address 1 bit 3 selects the bank that data writes go to: 0 for bank A, 1 for bank B. Writes to the bank that is not live do not change the pixel outputs.
- R6: Live mode 3 reads bank A and live mode 4 reads bank B. The output is (base + (delta*frac >> fw)) truncated to OUT_W.
- R7: The top log2(NUM_RGN) input bits pick the region, and the rest of the input is the local value. Address 8+r writes region r: offset in bits [7:0] and segment exponent s in bits [11:8], with s clamped to the local width L. Then fw = L-s, segment = local>>fw, frac = the low fw bits of local, and point = (offset+segment) mod NUM_PTS.
- R8: A write to address 0 sets a pending mode in bits [2:0]. The live mode takes the pending value only on a cycle where `frame_start` is high. `status_o` is 9 when the live mode is 3, 10 when it is 4, and 0 otherwise. It changes only at that boundary.
- R9: Live mode 1 outputs (x*x) >> (2*IN_W-OUT_W). Live mode 2 outputs the bitwise complement of the bypass value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| frame_start | input | 1 | Frame boundary pulse; commits the pending mode |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_i | input | 3*IN_W | Input pixel, red in the low field |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_o | output | 3*OUT_W | Output pixel, red in the low field |
| status_o | output | 4 | Live bank code (9 bank A, 10 bank B, 0 other) |

## Verification
The bench loads one bank while pixels stream from the other. A design that wrote to the live bank, or read from the bank being written, would show changed outputs in the middle of a frame. Mode writes are issued well before the frame pulse, and one write lands in the same cycle as the pulse. This exposes a mode that takes effect early, or a status code that moves with the pending mode instead of the live one. Three further cases are targeted: a masked partial reload, a load restarted by an index write in the middle of a point, and a region exponent above the local width that makes the point index wrap. These reveal a word position or index counter that drifts, a mask that blocks the wrong channel, and a missing clamp on the exponent.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

    localparam int CFG_W = 16;

    typedef enum logic [2:0] {
        GM_BYPASS  = 3'd0,
        GM_FIX_SQ  = 3'd1,
        GM_FIX_INV = 3'd2,
        GM_RAM_A   = 3'd3,
        GM_RAM_B   = 3'd4
    } gmode_e;

    localparam logic [3:0] ST_NONE  = 4'd0;
    localparam logic [3:0] ST_RAM_A = 4'd9;
    localparam logic [3:0] ST_RAM_B = 4'd10;

    localparam logic [3:0] A_MODE  = 4'd0;
    localparam logic [3:0] A_WCTRL = 4'd1;
    localparam logic [3:0] A_WIDX  = 4'd2;
    localparam logic [3:0] A_WDATA = 4'd3;
    localparam int         RGN_BASE = 8;

    typedef struct packed {
        logic [3:0] seg_log2;
        logic [7:0] offset;
    } rgn_cfg_t;

    function automatic logic [3:0] status_of(input logic [2:0] m);
        case (m)
            GM_RAM_A: return ST_RAM_A;
            GM_RAM_B: return ST_RAM_B;
            default:  return ST_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl
    import gamma_pkg::*;
#(
    parameter int NUM_PTS = 32,
    parameter int NUM_RGN = 4,
    parameter int VAL_W   = 12,
    localparam int PT_W   = $clog2(NUM_PTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             frame_start,
    output logic [2:0]       mode_live_o,
    output logic [3:0]       status_o,
    output rgn_cfg_t         rgn_o [NUM_RGN],
    output logic             wr_en_o,
    output logic             wr_bank_o,
    output logic             wr_is_delta_o,
    output logic [2:0]       wr_ch_sel_o,
    output logic [PT_W-1:0]  wr_idx_o,
    output logic [VAL_W-1:0] wr_val_o
);

    logic [2:0]      mode_pend_q, mode_live_q;
    logic [2:0]      mask_q;
    logic            wsel_q;
    logic [PT_W-1:0] idx_q;
    logic [2:0]      word_q;
    rgn_cfg_t        rgn_q [NUM_RGN];
    logic [1:0]      ch_sel;
    logic            unused_wdata;

    assign unused_wdata = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_pend_q <= GM_BYPASS;
            mode_live_q <= GM_BYPASS;
            mask_q      <= 3'b111;
            wsel_q      <= 1'b0;
            idx_q       <= '0;
            word_q      <= '0;
            for (int r = 0; r < NUM_RGN; r++) rgn_q[r] <= '0;
        end else begin
            if (frame_start) mode_live_q <= mode_pend_q;
            if (cfg_we) begin
                if (cfg_addr == A_MODE) mode_pend_q <= cfg_wdata[2:0];
                if (cfg_addr == A_WCTRL) begin
                    mask_q <= cfg_wdata[2:0];
                    wsel_q <= cfg_wdata[3];
                end
                if (cfg_addr == A_WIDX) begin
                    idx_q  <= cfg_wdata[PT_W-1:0];
                    word_q <= '0;
                end
                if (cfg_addr == A_WDATA) begin
                    if (word_q == 3'd5) begin
                        word_q <= '0;
                        idx_q  <= idx_q + 1'b1;
                    end else begin
                        word_q <= word_q + 3'd1;
                    end
                end
                for (int r = 0; r < NUM_RGN; r++)
                    if (cfg_addr == 4'(RGN_BASE + r)) rgn_q[r] <= rgn_cfg_t'(cfg_wdata[11:0]);
            end
        end
    end

    always_comb begin
        wr_is_delta_o = (word_q >= 3'd3);
        ch_sel        = wr_is_delta_o ? 2'(word_q - 3'd3) : word_q[1:0];
        wr_ch_sel_o   = mask_q & (3'b001 << ch_sel);
        wr_en_o       = cfg_we && (cfg_addr == A_WDATA);
        wr_bank_o     = wsel_q;
        wr_idx_o      = idx_q;
        wr_val_o      = cfg_wdata[VAL_W-1:0];
        mode_live_o   = mode_live_q;
        status_o      = status_of(mode_live_q);
        for (int r = 0; r < NUM_RGN; r++) rgn_o[r] = rgn_q[r];
    end

endmodule

// File: rtl/gamma_lut_store.sv
module gamma_lut_store #(
    parameter int NUM_PTS = 32,
    parameter int VAL_W   = 12,
    localparam int PT_W   = $clog2(NUM_PTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic             wr_is_delta,
    input  logic [2:0]       wr_ch_sel,
    input  logic [PT_W-1:0]  wr_idx,
    input  logic [VAL_W-1:0] wr_val,
    input  logic             rd_bank,
    input  logic [PT_W-1:0]  rd_idx   [3],
    output logic [VAL_W-1:0] rd_base  [3],
    output logic [VAL_W-1:0] rd_delta [3]
);

    logic [VAL_W-1:0] base_q  [2][3][NUM_PTS];
    logic [VAL_W-1:0] delta_q [2][3][NUM_PTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++)
                for (int c = 0; c < 3; c++)
                    for (int p = 0; p < NUM_PTS; p++) begin
                        base_q[b][c][p]  <= '0;
                        delta_q[b][c][p] <= '0;
                    end
        end else if (wr_en) begin
            for (int c = 0; c < 3; c++)
                if (wr_ch_sel[c]) begin
                    if (wr_is_delta) delta_q[wr_bank][c][wr_idx] <= wr_val;
                    else             base_q[wr_bank][c][wr_idx]  <= wr_val;
                end
        end
    end

    always_comb begin
        for (int c = 0; c < 3; c++) begin
            rd_base[c]  = base_q[rd_bank][c][rd_idx[c]];
            rd_delta[c] = delta_q[rd_bank][c][rd_idx[c]];
        end
    end

endmodule

// File: rtl/gamma_lut_chan.sv
module gamma_lut_chan
    import gamma_pkg::*;
#(
    parameter int IN_W    = 10,
    parameter int OUT_W   = 12,
    parameter int NUM_PTS = 32,
    parameter int NUM_RGN = 4,
    localparam int PT_W   = $clog2(NUM_PTS),
    localparam int RG_W   = $clog2(NUM_RGN),
    localparam int LW     = IN_W - RG_W,
    localparam int FW_W   = $clog2(LW + 1)
) (
    input  logic [IN_W-1:0]  x_i,
    input  logic [2:0]       mode_i,
    input  rgn_cfg_t         rgn_i [NUM_RGN],
    output logic [PT_W-1:0]  rd_idx_o,
    input  logic [OUT_W-1:0] rd_base_i,
    input  logic [OUT_W-1:0] rd_delta_i,
    output logic [OUT_W-1:0] y_o
);

    logic [RG_W-1:0]       rgn;
    logic [LW-1:0]         loc, seg_idx, frac;
    rgn_cfg_t              cfg;
    logic [FW_W-1:0]       s_cl, fw;
    logic [OUT_W+LW-1:0]   prod, scaled;
    logic [OUT_W:0]        sum;
    logic [2*IN_W-1:0]     sq;
    logic [OUT_W-1:0]      byp, y_ram;
    logic                  unused_bits;

    always_comb begin
        rgn     = x_i[IN_W-1 -: RG_W];
        loc     = x_i[LW-1:0];
        cfg     = rgn_i[rgn];
        s_cl    = (cfg.seg_log2 > 4'(LW)) ? FW_W'(LW) : FW_W'(cfg.seg_log2);
        fw      = FW_W'(LW) - s_cl;
        seg_idx = loc >> fw;
        frac    = loc & ({LW{1'b1}} >> s_cl);
        rd_idx_o = cfg.offset[PT_W-1:0] + seg_idx[PT_W-1:0];
        prod    = {{LW{1'b0}}, rd_delta_i} * {{OUT_W{1'b0}}, frac};
        scaled  = prod >> fw;
        sum     = {1'b0, rd_base_i} + {1'b0, scaled[OUT_W-1:0]};
        y_ram   = sum[OUT_W-1:0];
        sq      = {{IN_W{1'b0}}, x_i} * {{IN_W{1'b0}}, x_i};
        byp     = {x_i, {(OUT_W-IN_W){1'b0}}};
        case (mode_i)
            GM_FIX_SQ:          y_o = sq[2*IN_W-1 -: OUT_W];
            GM_FIX_INV:         y_o = ~byp;
            GM_RAM_A, GM_RAM_B: y_o = y_ram;
            default:            y_o = byp;
        endcase
    end

    assign unused_bits = ^{cfg.offset, seg_idx, scaled, sum[OUT_W], sq};

endmodule

// File: rtl/gamma_pwl_lut.sv
module gamma_pwl_lut
    import gamma_pkg::*;
#(
    parameter int IN_W    = 10,
    parameter int OUT_W   = 12,
    parameter int NUM_PTS = 32,
    parameter int NUM_RGN = 4,
    localparam int PT_W   = $clog2(NUM_PTS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [3:0]         cfg_addr,
    input  logic [15:0]        cfg_wdata,
    input  logic               frame_start,
    input  logic               pix_vld_i,
    input  logic [3*IN_W-1:0]  pix_i,
    output logic               pix_vld_o,
    output logic [3*OUT_W-1:0] pix_o,
    output logic [3:0]         status_o
);

    logic [2:0]       mode_live;
    rgn_cfg_t         rgn [NUM_RGN];
    logic             wr_en, wr_bank, wr_is_delta;
    logic [2:0]       wr_ch_sel;
    logic [PT_W-1:0]  wr_idx;
    logic [OUT_W-1:0] wr_val;
    logic [PT_W-1:0]  rd_idx   [3];
    logic [OUT_W-1:0] rd_base  [3];
    logic [OUT_W-1:0] rd_delta [3];
    logic [OUT_W-1:0] y        [3];

    gamma_lut_ctrl #(.NUM_PTS(NUM_PTS), .NUM_RGN(NUM_RGN), .VAL_W(OUT_W)) u_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start),
        .mode_live_o(mode_live), .status_o(status_o), .rgn_o(rgn),
        .wr_en_o(wr_en), .wr_bank_o(wr_bank), .wr_is_delta_o(wr_is_delta),
        .wr_ch_sel_o(wr_ch_sel), .wr_idx_o(wr_idx), .wr_val_o(wr_val)
    );

    gamma_lut_store #(.NUM_PTS(NUM_PTS), .VAL_W(OUT_W)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_is_delta(wr_is_delta), .wr_ch_sel(wr_ch_sel), .wr_idx(wr_idx),
        .wr_val(wr_val), .rd_bank(mode_live == GM_RAM_B), .rd_idx(rd_idx),
        .rd_base(rd_base), .rd_delta(rd_delta)
    );

    for (genvar c = 0; c < 3; c++) begin : g_chan
        gamma_lut_chan #(.IN_W(IN_W), .OUT_W(OUT_W), .NUM_PTS(NUM_PTS), .NUM_RGN(NUM_RGN)) u_chan (
            .x_i(pix_i[c*IN_W +: IN_W]), .mode_i(mode_live), .rgn_i(rgn),
            .rd_idx_o(rd_idx[c]), .rd_base_i(rd_base[c]),
            .rd_delta_i(rd_delta[c]), .y_o(y[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_vld_o <= 1'b0;
            pix_o     <= '0;
        end else begin
            pix_vld_o <= pix_vld_i;
            for (int c = 0; c < 3; c++) pix_o[c*OUT_W +: OUT_W] <= y[c];
        end
    end

endmodule

// File: rtl/gamma_pwl_lut_chk.sv
module gamma_pwl_lut_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_start,
    input logic       pix_vld_i,
    input logic       pix_vld_o,
    input logic [3:0] status_o
);

    // R1: reset clears the output valid
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !pix_vld_o);

    // R2: one-cycle valid pipeline
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        pix_vld_i |=> pix_vld_o);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !pix_vld_i |=> !pix_vld_o);

    // R8: only the three legal status codes appear
    a_r8_status_legal: assert property (@(posedge clk) disable iff (rst)
        (status_o == 4'd0) || (status_o == 4'd9) || (status_o == 4'd10));

    // R8: status moves only on a frame boundary
    a_r8_status_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(status_o));

endmodule

bind gamma_pwl_lut gamma_pwl_lut_chk u_chk (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .pix_vld_i(pix_vld_i), .pix_vld_o(pix_vld_o), .status_o(status_o)
);

// File: tb/gamma_pwl_lut_tb_top.sv
`timescale 1ns/1ps
module gamma_pwl_lut_tb_top;

    localparam int IN_W = 10;
    localparam int OUT_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic frame_start = 1'b0;
    logic pix_vld_i = 1'b0;
    logic [3*IN_W-1:0] pix_i = '0;
    logic pix_vld_o;
    logic [3*OUT_W-1:0] pix_o;
    logic [3:0] status_o;

    always #10 clk = ~clk;

    gamma_pwl_lut dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start),
        .pix_vld_i(pix_vld_i), .pix_i(pix_i), .pix_vld_o(pix_vld_o),
        .pix_o(pix_o), .status_o(status_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    string cur_req = "R2";

    // behavioural reference state
    int mb [2][3][32];
    int md [2][3][32];
    int roff [4];
    int rseg [4];
    int mpend = 0, mlive = 0, mmask = 7, mwsel = 0, midx = 0, mword = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_px(input int x);
        int r, loc, s, fw, seg, frac, pt, bk;
        case (mlive)
            1: return (x * x) >> 8;
            2: return 4095 - (x << 2);
            default: ;
        endcase
        if (mlive != 3 && mlive != 4) return x << 2;
        return 0;
    endfunction

    function automatic int ref_ram(input int ch, input int x);
        int r, loc, s, fw, seg, frac, pt, bk;
        bk = mlive - 3;
        r = x >> 8;
        loc = x & 255;
        s = (rseg[r] > 8) ? 8 : rseg[r];
        fw = 8 - s;
        seg = loc >> fw;
        frac = loc & ((1 << fw) - 1);
        pt = (roff[r] + seg) & 31;
        return (mb[bk][ch][pt] + ((md[bk][ch][pt] * frac) >> fw)) & 4095;
    endfunction

    function automatic int exp_status();
        return (mlive == 3) ? 9 : (mlive == 4) ? 10 : 0;
    endfunction

    task automatic step(input bit we, input int addr, input int data, input bit fs,
                        input bit pv, input int xr, input int xg, input int xb);
        int ex [3];
        int xs [3];
        bit ev;
        int ch;
        cfg_we = we; cfg_addr = 4'(addr); cfg_wdata = 16'(data);
        frame_start = fs; pix_vld_i = pv;
        pix_i = {10'(xb), 10'(xg), 10'(xr)};
        xs[0] = xr & 1023; xs[1] = xg & 1023; xs[2] = xb & 1023;
        ev = pv;
        for (int c = 0; c < 3; c++)
            ex[c] = (mlive == 3 || mlive == 4) ? ref_ram(c, xs[c]) : ref_px(xs[c]);
        if (fs) mlive = mpend;
        if (we) begin
            case (addr)
                0: mpend = data & 7;
                1: begin mmask = data & 7; mwsel = (data >> 3) & 1; end
                2: begin midx = data & 31; mword = 0; end
                3: begin
                    ch = mword % 3;
                    if ((mmask >> ch) & 1) begin
                        if (mword < 3) mb[mwsel][ch][midx] = data & 4095;
                        else           md[mwsel][ch][midx] = data & 4095;
                    end
                    mword++;
                    if (mword == 6) begin mword = 0; midx = (midx + 1) & 31; end
                end
                8, 9, 10, 11: begin
                    roff[addr-8] = data & 255;
                    rseg[addr-8] = (data >> 8) & 15;
                end
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0; frame_start = 0; pix_vld_i = 0;
        check(pix_vld_o == ev, "R2", "valid", int'(pix_vld_o), int'(ev));
        if (ev)
            for (int c = 0; c < 3; c++)
                check(int'(pix_o[c*OUT_W +: OUT_W]) == ex[c], cur_req, "pixel",
                      int'(pix_o[c*OUT_W +: OUT_W]), ex[c]);
        check(int'(status_o) == exp_status(), "R8", "status", int'(status_o), exp_status());
    endtask

    task automatic wr(input int addr, input int data);
        step(1, addr, data, 0, 0, 0, 0, 0);
    endtask

    task automatic px(input int i);
        step(0, 0, 0, 0, 1, (i * 7) & 1023, (i * 13 + 5) & 1023, (1023 - i * 11) & 1023);
    endtask

    task automatic frame();
        step(0, 0, 0, 1, 1, 1023, 0, 512);
    endtask

    function automatic int lut_val(input int bank, input int p, input int w);
        return ((p * 131 + w * 29 + bank * 577) * 7) & 4095;
    endfunction

    initial begin
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < 3; c++)
                for (int p = 0; p < 32; p++) begin mb[b][c][p] = 0; md[b][c][p] = 0; end
        for (int r = 0; r < 4; r++) begin roff[r] = 0; rseg[r] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check(pix_vld_o == 0, "R1", "valid", int'(pix_vld_o), 0);
        check(pix_o == '0, "R1", "pixel", int'(pix_o[11:0]), 0);
        check(status_o == 0, "R1", "status", int'(status_o), 0);

        cur_req = "R2";
        for (int i = 0; i < 20; i++) px(i * 53);
        step(0, 0, 0, 0, 1, 0, 1023, 1);
        step(0, 0, 0, 0, 0, 5, 5, 5);

        // R8: pending mode has no effect before the frame pulse
        cur_req = "R8";
        wr(0, 1);
        for (int i = 0; i < 6; i++) px(i + 3);
        frame();
        cur_req = "R9";
        for (int i = 0; i < 30; i++) px(i * 37);
        step(0, 0, 0, 0, 1, 1023, 1023, 0);
        // mode write in the same cycle as the frame pulse: old pending wins
        cur_req = "R8";
        step(1, 0, 2, 1, 1, 100, 200, 300);
        for (int i = 0; i < 4; i++) px(i);
        frame();
        cur_req = "R9";
        for (int i = 0; i < 20; i++) px(i * 41);
        wr(0, 5);
        frame();
        for (int i = 0; i < 10; i++) px(i * 97);

        // R7 region setup, one exponent above the local width
        wr(8, 16'h000);
        wr(9, 16'h201);
        wr(10, 16'h308);
        wr(11, 16'h910);
        // R3 load of bank A
        wr(1, 7);
        wr(2, 0);
        for (int p = 0; p < 32; p++)
            for (int w = 0; w < 6; w++) wr(3, lut_val(0, p, w));
        wr(0, 3);
        cur_req = "R6";
        frame();
        for (int i = 0; i < 200; i++) px(i);

        // R5 load bank B while bank A serves pixels
        cur_req = "R5";
        step(1, 1, 16'hF, 0, 1, 1, 2, 3);
        step(1, 2, 0, 0, 1, 4, 5, 6);
        for (int p = 0; p < 32; p++)
            for (int w = 0; w < 6; w++)
                step(1, 3, lut_val(1, p, w), 0, 1, (p * 32 + w * 5) & 1023, (p * 29) & 1023, (w * 170) & 1023);
        step(1, 0, 4, 0, 1, 9, 9, 9);
        cur_req = "R6";
        frame();
        for (int i = 0; i < 200; i++) px(i * 3);

        // R4 masked reload of inactive bank A, R3 index restart mid-point
        wr(1, 2);
        wr(2, 5);
        for (int w = 0; w < 6; w++) wr(3, 4095);
        wr(1, 7);
        wr(2, 6);
        wr(3, 2730);
        wr(3, 2730);
        wr(2, 6);
        for (int w = 0; w < 6; w++) wr(3, 100 + w * 50);
        cur_req = "R7";
        wr(8, 16'h304);
        wr(0, 3);
        frame();
        cur_req = "R3,R4";
        for (int i = 0; i < 256; i++) step(0, 0, 0, 0, 1, i, i, i);
        cur_req = "R7";
        for (int i = 768; i < 1024; i++) step(0, 0, 0, 0, 1, i, 1023 - i + 512, i - 256);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

endmodule